// File: doc/BRIEF.md
# Speculative Authentication Commit Gate

This block lets a core keep computing on values whose message-authentication check has not finished yet. Each architectural register carries a taint: a valid bit and a tag. The tag names the authentication-buffer entry whose verification the register's value still waits on. Loads take the tag of the buffer entry that holds their line. Computed results inherit the taint of the sources they use. When both sources are tainted, the result keeps the tag of the younger pending entry.

Buffer entries are allocated in a ring of 2^TAG_W slots and verify in allocation order. The block keeps a pointer to the oldest pending entry. Age is measured as the ring distance from that pointer, so tags may wrap. A verify broadcast names one entry. It clears every taint whose entry is at or before that entry in allocation order, and it moves the oldest pointer just past it.

Two kinds of action could leak or persist unverified results, and the block gates both. A store is held while its data or address register is tainted. An instruction-fetch miss is held while the last branch condition was computed from tainted data. A broadcast that reports an authentication failure raises a sticky fatal output. From that point every store request is dropped and every fetch miss is stalled.

Top module: `auth_commit_gate`

## Requirements
- R1: After reset every register is clean, `fatal` is low, the oldest pointer is entry 0, a store on any registers is granted (`st_go`=1) and a fetch miss is granted (`fe_go`=1).
- R2: A write with `wr_kind`=1 (load) sets the destination taint to `ld_tag` when `ld_pend`=1. It makes the destination clean when `ld_pend`=0.
- R3: A write with `wr_kind`=0 (compute) gives the destination the taint of the sources whose use flag (`wr_use_a`, `wr_use_b`) is 1. A source whose flag is 0 has no effect. With no tainted used source, the result is clean.
- R4: When both used sources are tainted, the result takes the tag farther from the oldest pending entry, where distance is (tag - oldest) mod 2^TAG_W. This holds across the wrap of the tag ring.
- R5: A passing verify (`vf_valid`=1, `vf_fail`=0) for entry V clears every taint T with (T - oldest) mod 2^TAG_W <= (V - oldest) mod 2^TAG_W. The oldest pointer then becomes V+1. Younger taints remain.
- R6: A store request gets exactly one of `st_go`, `st_stall` or `st_drop`. It stalls while either `st_src_a` or `st_src_b` is tainted and goes otherwise.
- R7: A passing verify takes effect in its own cycle. A store whose sources it covers goes in that cycle. A fetch miss whose branch taint it covers goes in that cycle. A register written in that cycle with a tag it covers ends up clean.
- R8: A branch (`br_valid`=1) records the taint of register `br_src`. From the next cycle, a fetch miss (`fe_req`) stalls while that recorded taint is uncleared. A later branch on a clean register releases fetch.
- R9: A failing verify (`vf_valid`=1, `vf_fail`=1) drops a store request in the same cycle. From the next cycle `fatal` stays high until reset, every store request is dropped and every fetch miss is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write this cycle |
| wr_kind | input | 1 | 1 = load, 0 = compute |
| wr_dst | input | RIDX_W | Destination register |
| wr_src_a | input | RIDX_W | First source register of a compute |
| wr_src_b | input | RIDX_W | Second source register of a compute |
| wr_use_a | input | 1 | First source is used |
| wr_use_b | input | 1 | Second source is used |
| ld_pend | input | 1 | Loaded line still awaits verification |
| ld_tag | input | TAG_W | Buffer entry holding the loaded line |
| vf_valid | input | 1 | Verify broadcast valid |
| vf_fail | input | 1 | Broadcast reports an authentication failure |
| vf_tag | input | TAG_W | Buffer entry the broadcast refers to |
| br_valid | input | 1 | Branch condition evaluated this cycle |
| br_src | input | RIDX_W | Register holding the branch operand |
| st_req | input | 1 | Store request |
| st_src_a | input | RIDX_W | Store data register |
| st_src_b | input | RIDX_W | Store address register |
| st_go | output | 1 | Store may issue |
| st_stall | output | 1 | Store must wait |
| st_drop | output | 1 | Store is discarded |
| fe_req | input | 1 | Instruction-fetch miss request |
| fe_go | output | 1 | Fetch miss may issue |
| fe_stall | output | 1 | Fetch miss must wait |
| fatal | output | 1 | Sticky integrity-failure exception |

## Verification
A verify broadcast can land in the same cycle as a store request or a fetch miss that it unblocks. It can also land in the same cycle as a register write that carries the very tag being verified. The bench sets up both collisions. It holds a tainted store and a tainted branch, then raises the matching verify in the same cycle, and expects the grant before the next edge. It also loads a register with the tag that is being verified in that cycle, and then expects a store on that register to go. A failing verify is placed in the same cycle as a store request, and the bench expects the drop in that cycle.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef enum logic {
    WK_ALU  = 1'b0,
    WK_LOAD = 1'b1
  } wr_kind_e;
endpackage

// File: rtl/acg_age_cover.sv
// Decides whether a passing verify for vf_tag covers a taint tag, by ring
// distance from the oldest pending entry.
module acg_age_cover #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] head,
  input  logic             vf_hit,
  input  logic [TAG_W-1:0] vf_tag,
  input  logic [TAG_W-1:0] tag,
  output logic             covered
);
  logic [TAG_W-1:0] dist_tag;
  logic [TAG_W-1:0] dist_vf;

  always_comb begin
    dist_tag = tag - head;
    dist_vf  = vf_tag - head;
    covered  = vf_hit && (dist_tag <= dist_vf);
  end
endmodule

// File: rtl/acg_youngest.sv
// Merges two source taints, keeping the younger pending entry.
module acg_youngest #(
  parameter int TAG_W = 4
) (
  input  logic [TAG_W-1:0] head,
  input  logic             a_v,
  input  logic [TAG_W-1:0] a_t,
  input  logic             b_v,
  input  logic [TAG_W-1:0] b_t,
  output logic             y_v,
  output logic [TAG_W-1:0] y_t
);
  logic [TAG_W-1:0] age_a;
  logic [TAG_W-1:0] age_b;

  always_comb begin
    age_a = a_t - head;
    age_b = b_t - head;
    y_v   = a_v || b_v;
    if (a_v && b_v) begin
      y_t = (age_b > age_a) ? b_t : a_t;
    end else if (b_v) begin
      y_t = b_t;
    end else begin
      y_t = a_t;
    end
  end
endmodule

// File: rtl/acg_taint_file.sv
// Per-register taint storage with same-cycle verify clearing.
module acg_taint_file #(
  parameter int N_REGS = 16,
  parameter int TAG_W  = 4,
  localparam int IDX_W = $clog2(N_REGS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [TAG_W-1:0]               head,
  input  logic                           vf_hit,
  input  logic [TAG_W-1:0]               vf_tag,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_dst,
  input  logic                           res_v,
  input  logic [TAG_W-1:0]               res_t,
  output logic [N_REGS-1:0]              eff_v,
  output logic [N_REGS-1:0][TAG_W-1:0]   tag_q
);
  logic [N_REGS-1:0]            v_q;
  logic [N_REGS-1:0]            v_d;
  logic [N_REGS-1:0][TAG_W-1:0] tag_d;
  logic [N_REGS-1:0]            cov;
  logic                         res_cov;

  for (genvar gi = 0; gi < N_REGS; gi++) begin : g_cov
    acg_age_cover #(.TAG_W(TAG_W)) u_cov (
      .head    (head),
      .vf_hit  (vf_hit),
      .vf_tag  (vf_tag),
      .tag     (tag_q[gi]),
      .covered (cov[gi])
    );
  end

  acg_age_cover #(.TAG_W(TAG_W)) u_res_cov (
    .head    (head),
    .vf_hit  (vf_hit),
    .vf_tag  (vf_tag),
    .tag     (res_t),
    .covered (res_cov)
  );

  always_comb begin
    for (int i = 0; i < N_REGS; i++) begin
      eff_v[i] = v_q[i] && !cov[i];
      if (wr_en && (wr_dst == IDX_W'(i))) begin
        v_d[i]   = res_v && !res_cov;
        tag_d[i] = res_t;
      end else begin
        v_d[i]   = eff_v[i];
        tag_d[i] = tag_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= '0;
      tag_q <= '0;
    end else begin
      v_q   <= v_d;
      tag_q <= tag_d;
    end
  end
endmodule

// File: rtl/acg_gate.sv
// Oldest-entry pointer, branch taint, fatal state and the store/fetch gates.
module acg_gate #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vf_valid,
  input  logic             vf_fail,
  input  logic [TAG_W-1:0] vf_tag,
  input  logic             br_valid,
  input  logic             br_v_in,
  input  logic [TAG_W-1:0] br_t_in,
  input  logic             st_req,
  input  logic             st_a_v,
  input  logic             st_b_v,
  input  logic             fe_req,
  output logic [TAG_W-1:0] head,
  output logic             vf_hit,
  output logic             st_go,
  output logic             st_stall,
  output logic             st_drop,
  output logic             fe_go,
  output logic             fe_stall,
  output logic             fatal
);
  logic [TAG_W-1:0] head_q, head_d;
  logic             bv_q, bv_d;
  logic [TAG_W-1:0] bt_q, bt_d;
  logic             fatal_q, fatal_d;
  logic             fail_now;
  logic             blocked;
  logic             bcov;
  logic             br_eff;

  acg_age_cover #(.TAG_W(TAG_W)) u_br_cov (
    .head    (head_q),
    .vf_hit  (vf_hit),
    .vf_tag  (vf_tag),
    .tag     (bt_q),
    .covered (bcov)
  );

  always_comb begin
    vf_hit   = vf_valid && !vf_fail;
    fail_now = vf_valid && vf_fail;
    blocked  = fatal_q || fail_now;
    br_eff   = bv_q && !bcov;

    head_d   = vf_hit ? (vf_tag + TAG_W'(1)) : head_q;
    bv_d     = br_valid ? br_v_in : br_eff;
    bt_d     = br_valid ? br_t_in : bt_q;
    fatal_d  = fatal_q || fail_now;

    st_drop  = st_req && blocked;
    st_stall = st_req && !blocked && (st_a_v || st_b_v);
    st_go    = st_req && !blocked && !(st_a_v || st_b_v);
    fe_stall = fe_req && (blocked || br_eff);
    fe_go    = fe_req && !(blocked || br_eff);

    head     = head_q;
    fatal    = fatal_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      bv_q    <= 1'b0;
      bt_q    <= '0;
      fatal_q <= 1'b0;
    end else begin
      head_q  <= head_d;
      bv_q    <= bv_d;
      bt_q    <= bt_d;
      fatal_q <= fatal_d;
    end
  end
endmodule

// File: rtl/auth_commit_gate.sv
module auth_commit_gate #(
  parameter int N_REGS = 16,
  parameter int TAG_W  = 4,
  localparam int RIDX_W = $clog2(N_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_kind,
  input  logic [RIDX_W-1:0] wr_dst,
  input  logic [RIDX_W-1:0] wr_src_a,
  input  logic [RIDX_W-1:0] wr_src_b,
  input  logic              wr_use_a,
  input  logic              wr_use_b,
  input  logic              ld_pend,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic              vf_valid,
  input  logic              vf_fail,
  input  logic [TAG_W-1:0]  vf_tag,
  input  logic              br_valid,
  input  logic [RIDX_W-1:0] br_src,
  input  logic              st_req,
  input  logic [RIDX_W-1:0] st_src_a,
  input  logic [RIDX_W-1:0] st_src_b,
  output logic              st_go,
  output logic              st_stall,
  output logic              st_drop,
  input  logic              fe_req,
  output logic              fe_go,
  output logic              fe_stall,
  output logic              fatal
);
  import acg_pkg::*;

  logic [TAG_W-1:0]             head;
  logic                         vf_hit;
  logic [N_REGS-1:0]            eff_v;
  logic [N_REGS-1:0][TAG_W-1:0] tag_q;
  logic                         a_v, b_v, alu_v, res_v;
  logic [TAG_W-1:0]             alu_t, res_t;
  wr_kind_e                     kind;

  always_comb begin
    kind  = wr_kind_e'(wr_kind);
    a_v   = eff_v[wr_src_a] && wr_use_a;
    b_v   = eff_v[wr_src_b] && wr_use_b;
    res_v = (kind == WK_LOAD) ? ld_pend : alu_v;
    res_t = (kind == WK_LOAD) ? ld_tag  : alu_t;
  end

  acg_youngest #(.TAG_W(TAG_W)) u_merge (
    .head (head),
    .a_v  (a_v),
    .a_t  (tag_q[wr_src_a]),
    .b_v  (b_v),
    .b_t  (tag_q[wr_src_b]),
    .y_v  (alu_v),
    .y_t  (alu_t)
  );

  acg_taint_file #(.N_REGS(N_REGS), .TAG_W(TAG_W)) u_file (
    .clk    (clk),
    .rst_n  (rst_n),
    .head   (head),
    .vf_hit (vf_hit),
    .vf_tag (vf_tag),
    .wr_en  (wr_en),
    .wr_dst (wr_dst),
    .res_v  (res_v),
    .res_t  (res_t),
    .eff_v  (eff_v),
    .tag_q  (tag_q)
  );

  acg_gate #(.TAG_W(TAG_W)) u_gate (
    .clk      (clk),
    .rst_n    (rst_n),
    .vf_valid (vf_valid),
    .vf_fail  (vf_fail),
    .vf_tag   (vf_tag),
    .br_valid (br_valid),
    .br_v_in  (eff_v[br_src]),
    .br_t_in  (tag_q[br_src]),
    .st_req   (st_req),
    .st_a_v   (eff_v[st_src_a]),
    .st_b_v   (eff_v[st_src_b]),
    .fe_req   (fe_req),
    .head     (head),
    .vf_hit   (vf_hit),
    .st_go    (st_go),
    .st_stall (st_stall),
    .st_drop  (st_drop),
    .fe_go    (fe_go),
    .fe_stall (fe_stall),
    .fatal    (fatal)
  );
endmodule

// File: rtl/acg_checker.sv
module acg_checker (
  input logic clk,
  input logic rst_n,
  input logic st_req,
  input logic st_go,
  input logic st_stall,
  input logic st_drop,
  input logic fe_req,
  input logic fe_go,
  input logic fe_stall,
  input logic vf_valid,
  input logic vf_fail,
  input logic fatal
);
  a_r6_store_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    st_req |-> ($countones({st_go, st_stall, st_drop}) == 1));

  a_r6_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !st_req |-> (!st_go && !st_stall && !st_drop));

  a_r8_fetch_one_answer: assert property (@(posedge clk) disable iff (!rst_n)
    fe_req |-> ($countones({fe_go, fe_stall}) == 1));

  a_r8_fetch_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fe_req |-> (!fe_go && !fe_stall));

  a_r9_fail_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_valid && vf_fail) |=> fatal);

  a_r9_fatal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |=> fatal);

  a_r9_fatal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    fatal |-> (!st_go && !fe_go));

  a_r9_fail_drops_now: assert property (@(posedge clk) disable iff (!rst_n)
    (vf_valid && vf_fail && st_req) |-> st_drop);
endmodule

bind auth_commit_gate acg_checker u_chk (.*);

// File: tb/tb_auth_commit_gate.sv
`timescale 1ns/1ps
module tb_auth_commit_gate;
  localparam int N_REGS = 16;
  localparam int TAG_W  = 4;
  localparam int RIDX_W = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_kind, wr_use_a, wr_use_b, ld_pend;
  logic [RIDX_W-1:0] wr_dst, wr_src_a, wr_src_b, br_src, st_src_a, st_src_b;
  logic [TAG_W-1:0] ld_tag, vf_tag;
  logic vf_valid, vf_fail, br_valid, st_req, fe_req;
  logic st_go, st_stall, st_drop, fe_go, fe_stall, fatal;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  auth_commit_gate #(.N_REGS(N_REGS), .TAG_W(TAG_W)) dut (.*);

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic idle();
    wr_en = 0; wr_kind = 0; wr_dst = 0; wr_src_a = 0; wr_src_b = 0;
    wr_use_a = 0; wr_use_b = 0; ld_pend = 0; ld_tag = 0;
    vf_valid = 0; vf_fail = 0; vf_tag = 0;
    br_valid = 0; br_src = 0; st_req = 0; st_src_a = 0; st_src_b = 0; fe_req = 0;
  endtask

  task automatic commit();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic do_load(int dst, logic pend, int tag);
    wr_en = 1; wr_kind = 1; wr_dst = RIDX_W'(dst); ld_pend = pend; ld_tag = TAG_W'(tag);
    commit();
  endtask

  task automatic do_alu(int dst, int a, int b, logic ua, logic ub);
    wr_en = 1; wr_kind = 0; wr_dst = RIDX_W'(dst);
    wr_src_a = RIDX_W'(a); wr_src_b = RIDX_W'(b); wr_use_a = ua; wr_use_b = ub;
    commit();
  endtask

  task automatic do_vf(int tag, logic fail);
    vf_valid = 1; vf_fail = fail; vf_tag = TAG_W'(tag);
    commit();
  endtask

  // {go, stall, drop}
  task automatic probe_st(string req, int a, int b, logic [2:0] exp);
    st_req = 1; st_src_a = RIDX_W'(a); st_src_b = RIDX_W'(b);
    #1;
    check(req, {1'b0, st_go, st_stall, st_drop}, {1'b0, exp});
    st_req = 0;
  endtask

  // {go, stall}
  task automatic probe_fe(string req, logic [1:0] exp);
    fe_req = 1;
    #1;
    check(req, {2'b0, fe_go, fe_stall}, {2'b0, exp});
    fe_req = 0;
  endtask

  task automatic t_reset();
    probe_st("R1 store after reset", 5, 9, 3'b100);
    probe_fe("R1 fetch after reset", 2'b10);
    check("R1 fatal low", {3'b0, fatal}, 4'b0);
  endtask

  task automatic t_load();
    do_load(1, 1, 3);
    probe_st("R2 pending load taints", 1, 0, 3'b010);
    probe_st("R6 address source tainted", 0, 1, 3'b010);
    do_load(2, 1, 3);
    do_load(2, 0, 0);
    probe_st("R2 clean load clears", 2, 2, 3'b100);
  endtask

  task automatic t_alu();
    do_alu(3, 1, 2, 1, 1);
    probe_st("R3 result inherits taint", 3, 0, 3'b010);
    do_alu(15, 1, 2, 0, 1);
    probe_st("R3 unused source ignored", 15, 0, 3'b100);
  endtask

  task automatic t_youngest();
    do_load(4, 1, 5);
    do_alu(5, 1, 4, 1, 1);
    do_vf(3, 0);
    probe_st("R5 verify clears r1", 1, 3, 3'b100);
    probe_st("R4 result kept younger tag", 5, 0, 3'b010);
    do_vf(5, 0);
    probe_st("R5 verify clears r5", 5, 4, 3'b100);
  endtask

  task automatic t_batch();
    do_load(6, 1, 7);
    do_load(7, 1, 8);
    do_vf(8, 0);
    probe_st("R5 younger verify clears older", 6, 7, 3'b100);
  endtask

  task automatic t_same_cycle();
    do_load(8, 1, 9);
    vf_valid = 1; vf_tag = 4'd9;
    probe_st("R7 verify releases store same cycle", 8, 0, 3'b100);
    commit();
    wr_en = 1; wr_kind = 1; wr_dst = 4'd9; ld_pend = 1; ld_tag = 4'd10;
    vf_valid = 1; vf_tag = 4'd10;
    commit();
    probe_st("R7 write covered by same-cycle verify", 9, 9, 3'b100);
  endtask

  task automatic t_branch();
    do_load(10, 1, 11);
    br_valid = 1; br_src = 4'd10;
    commit();
    probe_fe("R8 tainted branch stalls fetch", 2'b01);
    br_valid = 1; br_src = 4'd0;
    commit();
    probe_fe("R8 clean branch releases fetch", 2'b10);
    br_valid = 1; br_src = 4'd10;
    commit();
    vf_valid = 1; vf_tag = 4'd11;
    probe_fe("R7 verify releases fetch same cycle", 2'b10);
    commit();
    probe_fe("R8 fetch stays released", 2'b10);
  endtask

  task automatic t_wrap();
    do_load(11, 1, 14);
    do_load(12, 1, 1);
    do_alu(13, 11, 12, 1, 1);
    do_vf(14, 0);
    probe_st("R5 wrap verify clears r11", 11, 0, 3'b100);
    probe_st("R4 wrapped tag is younger", 13, 0, 3'b010);
    do_vf(1, 0);
    probe_st("R5 wrapped verify clears r13", 13, 12, 3'b100);
  endtask

  task automatic t_fatal();
    do_load(14, 1, 3);
    vf_valid = 1; vf_fail = 1; vf_tag = 4'd3;
    probe_st("R9 failing verify drops store", 14, 0, 3'b001);
    commit();
    check("R9 fatal raised", {3'b0, fatal}, 4'b0001);
    probe_st("R9 clean store dropped", 0, 0, 3'b001);
    probe_fe("R9 fetch stalled", 2'b01);
    do_vf(3, 0);
    check("R9 fatal sticky", {3'b0, fatal}, 4'b0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_alu();
    t_youngest();
    t_batch();
    t_same_cycle();
    t_branch();
    t_wrap();
    t_fatal();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule